// File: doc/BRIEF.md
# Three-Stage JK Counter with Stuck-At Fault Injection

This block is a 3-bit synchronous up-counter made of three JK flip-flop stages clocked on the same rising edge. The lowest stage toggles on every enabled clock. The middle stage has both J and K tied to the lowest stage's output. The top stage takes both J and K from a two-input AND gate. One AND input comes from the lowest stage and the other comes from the middle stage.

A fault-select input can tie either AND input to a constant 0 or a constant 1. This lets the wrong count sequences of a damaged gate be reproduced on demand.

A plain binary reference counter runs in step with the JK chain. A registered mismatch flag and a sticky error bit report any cycle in which the two counts differ. The block is meant for fault-behaviour study and for self-test of the counting path. The observer only needs to watch the count and the two flags.

Top module: `jk_fault_counter`

## Requirements
- R1: A synchronous active-high `rst`, sampled at a rising edge, sets `q`, `ref_q`, `mismatch` and `err_latched` to zero after that edge.
- R2: With `cnt_en` high, stage 0 (`q[0]`) inverts at every rising edge.
- R3: With `cnt_en` high, stage 1 (`q[1]`) inverts at an edge exactly when `q[0]` was 1 just before that edge. All stages use pre-edge values.
- R4: Stage 2 (`q[2]`) inverts at an edge when the AND gate output was 1 before the edge. The fault-free inputs are `q[0]` and `q[1]`. With no fault, `q` counts 0,1,...,7,0 in binary, with `q[0]` as the least significant bit.
- R5: `fault_sel` values: 3'b001 forces AND input 1 (the `q[0]` side) to 0; 3'b010 forces it to 1; 3'b011 forces AND input 2 (the `q[1]` side) to 0; 3'b100 forces it to 1. Every other code means no fault.
- R6: With `fault_sel` = 3'b100 and `cnt_en` high, starting from zero, `q` reads 1, 6, 7, 0, 1 after five edges. Stages 1 and 2 then toggle together.
- R7: With `cnt_en` high, `ref_q` increments by one modulo 8 at each edge, whatever the fault setting.
- R8: While `cnt_en` is low, all J and K inputs are 0, so `q` and `ref_q` hold their values.
- R9: `mismatch` after an edge equals (`q` != `ref_q`) as held just before that edge.
- R10: `err_latched` becomes 1 after any edge at which `q` != `ref_q` held before the edge. Only `rst` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all stages |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable; low holds every stage |
| fault_sel | input | 3 | Stuck-at fault selection code |
| q | output | 3 | JK counter state, bit 0 = stage 0 |
| ref_q | output | 3 | Fault-free reference count |
| mismatch | output | 1 | Registered compare of q against ref_q |
| err_latched | output | 1 | Sticky mismatch indicator |

## Verification
Each stage's register drives the `q` port directly, so a wrong stage value shows on the very next edge. A wrong toggle decision in the AND path appears in `q[2]` one edge after the enabling pattern. The bench checks it under every fault code and compares it against a bench model of the JK equations.

A fault in the compare logic shows one edge later, on `mismatch`. It persists on `err_latched` until reset. The bench therefore checks both flags after every edge, across random fault switching and count-enable gaps.

// File: rtl/jk_fault_counter.sv
module jk_fault_counter #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [SEL_W-1:0] fault_sel,
  output logic [2:0]       q,
  output logic [2:0]       ref_q,
  output logic             mismatch,
  output logic             err_latched
);

  localparam logic [SEL_W-1:0] F_IN1_LO = SEL_W'(1);
  localparam logic [SEL_W-1:0] F_IN1_HI = SEL_W'(2);
  localparam logic [SEL_W-1:0] F_IN2_LO = SEL_W'(3);
  localparam logic [SEL_W-1:0] F_IN2_HI = SEL_W'(4);

  function automatic logic jk_next(input logic j, input logic k, input logic cur);
    return (j & ~cur) | (~k & cur);
  endfunction

  logic and_a, and_b, gate_out;
  logic [2:0] jk_in;
  logic [2:0] q_nx;

  always_comb begin
    and_a = q[0];
    and_b = q[1];
    case (fault_sel)
      F_IN1_LO: and_a = 1'b0;
      F_IN1_HI: and_a = 1'b1;
      F_IN2_LO: and_b = 1'b0;
      F_IN2_HI: and_b = 1'b1;
      default:  ;
    endcase
  end

  assign gate_out = and_a & and_b;
  assign jk_in    = cnt_en ? {gate_out, q[0], 1'b1} : 3'b000;

  assign q_nx[0] = jk_next(jk_in[0], jk_in[0], q[0]);
  assign q_nx[1] = jk_next(jk_in[1], jk_in[1], q[1]);
  assign q_nx[2] = jk_next(jk_in[2], jk_in[2], q[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      q           <= '0;
      ref_q       <= '0;
      mismatch    <= 1'b0;
      err_latched <= 1'b0;
    end else begin
      q           <= q_nx;
      if (cnt_en) ref_q <= ref_q + 3'd1;
      mismatch    <= (q != ref_q);
      err_latched <= err_latched | (q != ref_q);
    end
  end

  p_stage0_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> q[0] != $past(q[0]));

  p_stage1_follow_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> q[1] == ($past(q[1]) ^ $past(q[0])));

  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(q) && $stable(ref_q));

  p_ref_increment_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_en |=> ref_q == $past(ref_q) + 3'd1);

  p_clean_tracks_r4: assert property (@(posedge clk) disable iff (rst)
    (fault_sel == '0 && q == ref_q) |=> q == ref_q);

  p_flag_on_diff_r9: assert property (@(posedge clk) disable iff (rst)
    (q != ref_q) |=> mismatch && err_latched);

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_latched |=> err_latched);

endmodule

// File: tb/test_jk_fault_counter.sv
module test_jk_fault_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, cnt_en;
  logic [2:0] fault_sel;
  logic [2:0] q, ref_q;
  logic mismatch, err_latched;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] m_q, m_ref;
  logic m_mm, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  jk_fault_counter i_jk_fault_counter (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .fault_sel(fault_sel),
    .q(q), .ref_q(ref_q), .mismatch(mismatch), .err_latched(err_latched)
  );

  function automatic logic [2:0] model_next(input logic [2:0] cur, input logic [2:0] fs, input logic en);
    logic a, b;
    logic [2:0] t;
    a = cur[0];
    b = cur[1];
    if (fs == 3'b001) a = 1'b0;
    if (fs == 3'b010) a = 1'b1;
    if (fs == 3'b011) b = 1'b0;
    if (fs == 3'b100) b = 1'b1;
    t = en ? {a & b, cur[0], 1'b1} : 3'b000;
    return cur ^ t;
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic r, input logic en, input logic [2:0] fs);
    @(negedge clk);
    rst = r; cnt_en = en; fault_sel = fs;
    @(posedge clk);
    #1;
    if (r) begin
      m_q = '0; m_ref = '0; m_mm = 0; m_err = 0;
    end else begin
      m_mm  = (m_q != m_ref);
      m_err = m_err | m_mm;
      m_q   = model_next(m_q, fs, en);
      if (en) m_ref = m_ref + 3'd1;
    end
  endtask

  task automatic check_all(input logic [2:0] fs);
    check("R2 stage0", {3'b0, q[0]}, {3'b0, m_q[0]});
    check("R3 stage1", {3'b0, q[1]}, {3'b0, m_q[1]});
    if (fs inside {3'b001, 3'b010, 3'b011, 3'b100})
      check("R5 stage2 faulted", {3'b0, q[2]}, {3'b0, m_q[2]});
    else
      check("R4 stage2", {3'b0, q[2]}, {3'b0, m_q[2]});
    check("R7 reference", {1'b0, ref_q}, {1'b0, m_ref});
    check("R9 mismatch", {3'b0, mismatch}, {3'b0, m_mm});
    check("R10 sticky", {3'b0, err_latched}, {3'b0, m_err});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] seq6 [5];
    logic [2:0] fs;
    logic [2:0] held_q, held_r;
    void'($urandom(32'd1234));
    rst = 1; cnt_en = 0; fault_sel = 0;
    m_q = 'x; m_ref = 'x; m_mm = 'x; m_err = 'x;

    step(1, 0, 0);
    check("R1 reset", {1'b0, q}, 4'h0);
    check("R1 reset ref", {1'b0, ref_q}, 4'h0);
    check("R1 reset flags", {2'b0, mismatch, err_latched}, 4'h0);

    for (int i = 0; i < 10; i++) begin
      step(0, 1, 3'b000);
      check("R4 binary count", {1'b0, q}, 4'((i + 1) % 8));
      check_all(3'b000);
    end

    step(1, 0, 0);
    seq6 = '{3'd1, 3'd6, 3'd7, 3'd0, 3'd1};
    for (int i = 0; i < 5; i++) begin
      step(0, 1, 3'b100);
      check("R6 stuck-high sequence", {1'b0, q}, {1'b0, seq6[i]});
      check_all(3'b100);
    end

    held_q = q; held_r = ref_q;
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 3'b100);
      check("R8 hold q", {1'b0, q}, {1'b0, held_q});
      check("R8 hold ref", {1'b0, ref_q}, {1'b0, held_r});
      check_all(3'b100);
    end

    for (int c = 0; c < 8; c++) begin
      step(1, 0, 0);
      for (int i = 0; i < 12; i++) begin
        step(0, 1, 3'(c));
        check_all(3'(c));
      end
    end

    step(1, 0, 0);
    fs = 0;
    for (int i = 0; i < 3000; i++) begin
      logic r, en;
      r  = ($urandom_range(0, 63) == 0);
      en = ($urandom_range(0, 7) != 0);
      if ($urandom_range(0, 15) == 0) fs = 3'($urandom_range(0, 7));
      step(r, en, fs);
      if (r) check("R1 random reset", {1'b0, q}, 4'h0);
      check_all(fs);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule